// File: doc/BRIEF.md
# Serial Interrupt Slot Encoder (device side)

This block sits on the device end of a single shared, open-drain serial interrupt wire. A host opens each cycle with a low start pulse. After that, every interrupt owns a fixed three-clock slot on the wire. The encoder watches the wire and finds the rising edge that ends each start pulse. It then counts clocks from that edge, and in the slots it owns it reports each interrupt level that is both enabled and allowed. After the last slot it reads the length of the host's stop pulse, which sets whether the next cycle may be opened by the device. In quiet mode the device opens a cycle itself with a one-clock low pulse when its reported interrupt picture has changed.

The pad is open-drain. `drv_oe` enables the driver, `drv_o` is the value driven, and `line_i` is the resolved state of the wire. The slot count, the set of slots the device may drive and the pulse-length thresholds are parameters.

Top module: `sirq_encoder`

## Requirements
- R1: After reset the encoder is in continuous mode and releases the wire (`drv_oe`=0, `drv_o`=0). It does not open a cycle itself, whatever the interrupt inputs do, until a stop pulse selects quiet mode.
- R2: A low run of at least 4 clocks on `line_i`, ended by a high clock, is a start pulse. Clock 0 is the first high clock after the run. Clocks 0 and 1 of the cycle are released.
- R3: Slot k (0-based, 16 slots) samples at clock 3k+2. In that clock the encoder drives low (`drv_oe`=1, `drv_o`=0) when `irq_lvl[k]` and `irq_en[k]` are both 1 and k is drivable. Otherwise it releases the wire.
- R4: In the clock after a driven-low sample clock, the encoder drives high (`drv_oe`=1, `drv_o`=1). It releases the wire in the turn-around clock that follows. Slots it did not drive stay released in all three clocks.
- R5: Only slots 3, 4, 5, 9, 10 and 11 are drivable (mask 16'h0E38). Every other slot stays released even when its level and enable are 1.
- R6: An interrupt whose `irq_en` bit is 0 is not reported in its slot.
- R7: A low pulse after the last slot selects the next mode from its length: 2 clocks selects quiet mode and 3 clocks selects continuous mode.
- R8: In quiet mode, while idle with the wire high, the encoder drives the wire low for exactly one clock and then releases it. It does this when the masked, enabled level vector differs from the one captured at the end of the last completed cycle.
- R9: In quiet mode, with no change since the last completed cycle, the encoder does not open a cycle.
- R10: A low run shorter than 4 clocks while idle does not start slot counting.
- R11: Whenever `drv_oe` is 0, `drv_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| line_i | input | 1 | Resolved state of the shared serial interrupt wire |
| irq_lvl | input | 16 | Interrupt levels, bit k belongs to slot k |
| irq_en | input | 16 | Per-slot report enable |
| drv_oe | output | 1 | Pad driver enable |
| drv_o | output | 1 | Value driven while `drv_oe` is 1 |

## Verification
The assertions check several rules on every cycle:
- a driven-low sample is followed by one high recovery clock and then a release;
- at most one slot is sampling in any clock;
- a low drive falls only on a drivable slot;
- the self-start lasts one clock and happens only in quiet mode;
- the drive value rests low whenever the driver is off.

Other behaviour only the bench scenarios can show. These are the absolute slot timing measured from the end of start pulses of different lengths, the enable and mask filtering for chosen level patterns, the mode change caused by 2-clock and 3-clock stop pulses, the rejection of short low pulses, and whether a quiet-mode request is raised at all for changed or unchanged levels.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_SLOTS = 2'd2,
      ST_STOP  = 2'd3
   } sirq_state_e;

   typedef enum logic {
      MODE_CONT  = 1'b0,
      MODE_QUIET = 1'b1
   } sirq_mode_e;
endpackage

// File: rtl/sirq_pulse_meter.sv
`timescale 1ns/1ps
// Measures the length of the current low run on the wire and flags the
// clock in which a low run ends.
module sirq_pulse_meter #(
   parameter int RUN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   output logic [RUN_W-1:0] run_len,
   output logic             rise_o
);
   localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (!line_i) begin
         if (run_len != RUN_SAT) run_len <= run_len + 1'b1;
      end else begin
         run_len <= '0;
      end
   end

   // high now, low run recorded up to the last edge
   assign rise_o = line_i && (run_len != '0);

   // R2: a run end is a single event, never two clocks in a row
   p_rise_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/sirq_frame_ctl.sv
`timescale 1ns/1ps
// Cycle sequencer: start detection, slot clock counter, stop decoding,
// mode register and quiet-mode self start.
module sirq_frame_ctl
   import sirq_pkg::*;
#(
   parameter int NUM_SLOTS      = 16,
   parameter int RUN_W          = 4,
   parameter int START_MIN      = 4,
   parameter int STOP_QUIET_LEN = 2,
   parameter int STOP_CONT_LEN  = 3,
   parameter int CNT_W          = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_i,
   input  logic                 rise,
   input  logic [RUN_W-1:0]     run_len,
   input  logic [NUM_SLOTS-1:0] eff,
   output logic                 in_frame,
   output logic [CNT_W-1:0]     cnt,
   output logic                 req_drive,
   output logic                 mode_quiet
);
   localparam int               FRAME_LAST = 3*NUM_SLOTS + 1;
   localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(FRAME_LAST);
   localparam logic [RUN_W-1:0] START_V    = RUN_W'(START_MIN);
   localparam logic [RUN_W-1:0] STOP_Q_V   = RUN_W'(STOP_QUIET_LEN);
   localparam logic [RUN_W-1:0] STOP_C_V   = RUN_W'(STOP_CONT_LEN);

   sirq_state_e          state;
   sirq_mode_e           mode;
   logic [NUM_SLOTS-1:0] snap;
   logic                 long_run;

   assign long_run = rise && (run_len >= START_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         mode  <= MODE_CONT;
         cnt   <= '0;
         snap  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (long_run) begin
                  state <= ST_SLOTS;
                  cnt   <= CNT_W'(1);
               end else if (mode == MODE_QUIET && line_i && eff != snap) begin
                  state <= ST_REQ;
               end
            end
            ST_REQ: state <= ST_IDLE;
            ST_SLOTS: begin
               if (cnt == CNT_LAST) begin
                  state <= ST_STOP;
                  snap  <= eff;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (long_run) begin
                  state <= ST_SLOTS;
                  cnt   <= CNT_W'(1);
               end else if (rise) begin
                  if (run_len == STOP_Q_V)      mode <= MODE_QUIET;
                  else if (run_len == STOP_C_V) mode <= MODE_CONT;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_frame   = (state == ST_SLOTS);
   assign req_drive  = (state == ST_REQ);
   assign mode_quiet = (mode == MODE_QUIET);

   // R8: the self-started low lasts one clock, then the wire is released
   p_req_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ) |=> (state == ST_IDLE));
   // R2: slot counting begins at clock 1 right after entering a cycle
   p_frame_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_SLOTS) |-> (cnt == CNT_W'(1)));
   // R1: continuous mode never self-starts
   p_cont_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CONT && state == ST_IDLE) |=> (state != ST_REQ));
endmodule

// File: rtl/sirq_slot_drv.sv
`timescale 1ns/1ps
// Per-slot decode: sample hit, drivable filter, low/high/release sequence.
module sirq_slot_drv #(
   parameter int                   NUM_SLOTS  = 16,
   parameter logic [NUM_SLOTS-1:0] DRIVE_MASK = 16'h0E38,
   parameter int                   CNT_W      = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_frame,
   input  logic [CNT_W-1:0]     cnt,
   input  logic [NUM_SLOTS-1:0] lvl,
   input  logic [NUM_SLOTS-1:0] en,
   output logic                 slot_oe,
   output logic                 slot_o
);
   logic [NUM_SLOTS-1:0] sample_hit;
   logic [NUM_SLOTS-1:0] act;
   logic                 drive_low;
   logic                 drove_q;

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      localparam int SAMPLE_AT = 3*k + 2;
      assign sample_hit[k] = in_frame && (cnt == CNT_W'(SAMPLE_AT));
      if (DRIVE_MASK[k]) begin : g_own
         assign act[k] = lvl[k] & en[k];
      end else begin : g_foreign
         assign act[k] = 1'b0;
      end
   end

   assign drive_low = |(sample_hit & act);

   always_ff @(posedge clk) begin
      if (!rst_n) drove_q <= 1'b0;
      else        drove_q <= drive_low;
   end

   assign slot_oe = drive_low | drove_q;
   assign slot_o  = drove_q;

   // R3: at most one slot samples in any clock
   p_one_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sample_hit));
   // R4: a low sample is followed by one high recovery clock
   p_recover_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |=> (slot_oe && slot_o));
   // R4: after recovery the turn-around clock is released
   p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_oe && slot_o) |=> !slot_oe);
   // R5: low drive only lands on drivable slots
   p_drive_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |-> ((sample_hit & DRIVE_MASK) != '0));
endmodule

// File: rtl/sirq_encoder.sv
`timescale 1ns/1ps
module sirq_encoder #(
   parameter int                   NUM_SLOTS      = 16,
   parameter logic [NUM_SLOTS-1:0] DRIVE_MASK     = 16'h0E38,
   parameter int                   START_MIN      = 4,
   parameter int                   STOP_QUIET_LEN = 2,
   parameter int                   STOP_CONT_LEN  = 3,
   parameter int                   RUN_W          = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_i,
   input  logic [NUM_SLOTS-1:0] irq_lvl,
   input  logic [NUM_SLOTS-1:0] irq_en,
   output logic                 drv_oe,
   output logic                 drv_o
);
   localparam int FRAME_LAST = 3*NUM_SLOTS + 1;
   localparam int CNT_W      = $clog2(FRAME_LAST + 1);

   initial begin : elab_checks
      assert (NUM_SLOTS >= 1 && NUM_SLOTS <= 32)
         else $error("NUM_SLOTS out of range");
      assert (START_MIN > STOP_CONT_LEN && START_MIN > STOP_QUIET_LEN)
         else $error("start threshold must exceed stop lengths");
      assert (STOP_QUIET_LEN != STOP_CONT_LEN)
         else $error("stop lengths must differ");
      assert (((1 << RUN_W) - 1) > START_MIN)
         else $error("RUN_W too narrow for START_MIN");
   end

   logic [RUN_W-1:0]     run_len;
   logic                 rise;
   logic                 in_frame;
   logic [CNT_W-1:0]     cnt;
   logic                 req_drive;
   logic                 mode_quiet;
   logic                 slot_oe;
   logic                 slot_o;
   logic [NUM_SLOTS-1:0] eff;

   assign eff = irq_lvl & irq_en & DRIVE_MASK;

   sirq_pulse_meter #(.RUN_W(RUN_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_i),
      .run_len (run_len),
      .rise_o  (rise)
   );

   sirq_frame_ctl #(
      .NUM_SLOTS      (NUM_SLOTS),
      .RUN_W          (RUN_W),
      .START_MIN      (START_MIN),
      .STOP_QUIET_LEN (STOP_QUIET_LEN),
      .STOP_CONT_LEN  (STOP_CONT_LEN),
      .CNT_W          (CNT_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .rise       (rise),
      .run_len    (run_len),
      .eff        (eff),
      .in_frame   (in_frame),
      .cnt        (cnt),
      .req_drive  (req_drive),
      .mode_quiet (mode_quiet)
   );

   sirq_slot_drv #(
      .NUM_SLOTS  (NUM_SLOTS),
      .DRIVE_MASK (DRIVE_MASK),
      .CNT_W      (CNT_W)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_frame (in_frame),
      .cnt      (cnt),
      .lvl      (irq_lvl),
      .en       (irq_en),
      .slot_oe  (slot_oe),
      .slot_o   (slot_o)
   );

   assign drv_oe = slot_oe | req_drive;
   assign drv_o  = slot_o & ~req_drive;

   // R11: the drive value rests low whenever the driver is off
   p_val_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_oe |-> !drv_o);
   // R8: a self-start only happens in quiet mode
   p_req_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_drive |-> mode_quiet);
   // R1: outside a cycle in continuous mode the wire is never driven
   p_cont_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_quiet && !in_frame) |-> !drv_oe);
endmodule

// File: tb/sirq_encoder_tb_top.sv
`timescale 1ns/1ps
module sirq_encoder_tb_top;
   localparam int          N     = 16;
   localparam logic [15:0] MASKB = 16'h0E38;

   typedef struct {
      bit    oe;
      bit    o;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_low = 1'b0;
   logic [N-1:0]  irq_lvl = '0;
   logic [N-1:0]  irq_en = '0;
   logic          drv_oe;
   logic          drv_o;
   logic          line;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   assign line = !(host_low || (drv_oe && !drv_o));

   sirq_encoder dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line),
      .irq_lvl (irq_lvl),
      .irq_en  (irq_en),
      .drv_oe  (drv_oe),
      .drv_o   (drv_o)
   );

   // monitor: one expectation per clock, compared mid-cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (drv_oe !== e.oe || drv_o !== e.o) begin
            n_bad++;
            $display("FAIL %s: actual oe=%0b o=%0b expected oe=%0b o=%0b at %0t",
                     e.tag, drv_oe, drv_o, e.oe, e.o, $time);
         end
      end
   end

   task automatic cyc(input bit hl, input bit eoe, input bit eo, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      host_low = hl;
      e.oe = eoe; e.o = eo; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic host_start(input int len);
      for (int i = 0; i < len; i++) cyc(1'b1, 1'b0, 1'b0, "R2");
   endtask

   task automatic host_stop(input int len);
      for (int i = 0; i < len; i++) cyc(1'b1, 1'b0, 1'b0, "R7");
      cyc(1'b0, 1'b0, 1'b0, "R7");
   endtask

   // slot clocks 0 .. 3N+1, expectations from the requirements
   task automatic frame();
      for (int c = 0; c <= 3*N + 1; c++) begin
         bit    eoe = 1'b0;
         bit    eo  = 1'b0;
         string tag = "R2";
         if (c >= 2 && (c - 2) % 3 == 0) begin
            int k = (c - 2) / 3;
            tag = "R3";
            if (irq_lvl[k] && irq_en[k] && MASKB[k]) eoe = 1'b1;
            else if (irq_lvl[k] && irq_en[k])        tag = "R5";
            else if (irq_lvl[k] && MASKB[k])         tag = "R6";
         end else if (c >= 3 && c % 3 == 0) begin
            int k = (c - 3) / 3;
            tag = "R4";
            if (irq_lvl[k] && irq_en[k] && MASKB[k]) begin
               eoe = 1'b1; eo = 1'b1;
            end
         end else if (c >= 2) begin
            tag = "R4";
         end
         cyc(1'b0, eoe, eo, tag);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if (drv_oe !== 1'b0 || drv_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: reset actual oe=%0b o=%0b expected oe=0 o=0", drv_oe, drv_o);
      end
      rst_n = 1'b1;

      // R1: continuous after reset, level changes cause no self start
      idle(3, "R1");
      irq_lvl = 16'hFFFF; irq_en = 16'hFFFF;
      idle(8, "R1");

      // R10: a 3-clock low while idle is not a start
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, "R10");
      idle(12, "R10");

      // R3/R5: all levels and enables set, only drivable slots report
      host_start(4);
      frame();
      host_stop(3);
      idle(4, "R1");

      // R6: slot 9 disabled; longer start pulse; stop selects quiet (R7)
      irq_lvl = 16'h0A28; irq_en = 16'hFDFF;
      idle(2, "R1");
      host_start(6);
      frame();
      host_stop(2);

      // R9: quiet mode with unchanged levels stays silent
      idle(10, "R9");

      // R8: level change in quiet mode -> one-clock self start
      irq_lvl = 16'h0A38;
      cyc(1'b0, 1'b1, 1'b0, "R8");
      host_start(3);
      frame();
      host_stop(3);

      // R7: back in continuous mode, a change raises no request
      irq_lvl = 16'h0010;
      idle(10, "R7");

      // R3: single drivable slot at the top edge of the set
      irq_lvl = 16'h0800; irq_en = 16'h0800;
      host_start(5);
      frame();
      host_stop(3);
      idle(3, "R1");

      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2: watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule